// File: doc/BRIEF.md
# Fixed-Point Vector Element ALU

This block computes one fixed-point result per cycle for a single vector lane of element width SEW. It takes a first operand, a second operand and an operation code, and returns an SEW-bit result and a saturation flag one clock later. The operations cover saturating add and subtract (signed and unsigned), averaging add and subtract, a signed fractional multiply, scaling right shifts, and narrowing clips. The narrowing clips take a source that is 2*SEW bits wide.

The second operand comes from one of three places: a vector element, a scalar register value, or a 5-bit immediate. A 2-bit rounding mode controls how bits dropped by a right shift are folded back into the result. This rounding rule is shared by the averaging, multiply, shift and clip operations.

The enclosing vector unit steps through the lanes, applies masking and collects the flag into a sticky status bit. None of that happens here.

Top module: `fxalu`

## Requirements
- R1: Result, flag and `out_valid` are registered. An operation presented with `in_valid` high appears at the outputs after the next rising clock edge. A cycle with `in_valid` low gives `out_valid` low. Synchronous reset clears all three outputs to zero.
- R2: Opcode 0 (unsigned saturating add) adds the two operands as unsigned values. A sum above the unsigned maximum gives all ones with `sat` high; otherwise it gives the exact sum with `sat` low.
- R3: Opcode 2 (unsigned saturating subtract) gives zero with `sat` high when the first operand is below the second as unsigned values. Otherwise it gives the exact difference with `sat` low.
- R4: Opcodes 1 (signed add) and 3 (signed subtract) compute the exact two's-complement result. A result above +2^(SEW-1)-1 clamps to that value and a result below -2^(SEW-1) clamps to that value; either clamp raises `sat`.
- R5: Opcodes 4, 5, 6 and 7 (averaging add unsigned, add signed, subtract unsigned, subtract signed) form the SEW+1-bit sum or difference. Operands are zero-extended for the unsigned forms and sign-extended for the signed forms. The result is that value shifted right by one, plus the rounding increment for one dropped bit. `sat` stays low.
- R6: Opcode 8 (fractional multiply) forms the 2*SEW-bit signed product, shifts it right by SEW-1 and adds the rounding increment. It then clamps to the signed SEW-bit range. Only the most-negative times most-negative case clamps, giving the signed maximum with `sat` high.
- R7: Opcodes 9 (logical) and 10 (arithmetic) shift the first operand right by the low log2(SEW) bits of the second operand, then add the rounding increment. `sat` stays low.
- R8: Rounding mode encodes how the increment is formed. 0 adds the most significant dropped bit. 1 rounds to nearest with ties to even. 2 truncates. 3 sets the result LSB when any dropped bit is one (round to odd).
- R9: Opcodes 11 (unsigned) and 12 (signed) clip a 2*SEW-bit source. The source is shifted right (arithmetically for 12) by the second operand modulo 2*SEW, the rounding increment is added, and the value is clamped to the SEW-bit unsigned or signed range. A clamp raises `sat`.
- R10: Source select 1 takes the second operand from the scalar input, 2 from the immediate, and 0 or 3 from the vector input. The immediate is zero-extended for opcodes 9 to 12 and sign-extended for all others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| rmode_i | input | 2 | Rounding mode |
| bsrc_i | input | 2 | Second operand source select |
| opa_i | input | 2*SEW | First operand; low SEW bits except for clips |
| vec_b_i | input | SEW | Second operand from a vector element |
| scl_b_i | input | SEW | Second operand from a scalar register |
| imm_i | input | 5 | Immediate second operand |
| out_valid | output | 1 | Result valid |
| result_o | output | SEW | Fixed-point result |
| sat_o | output | 1 | A clamp changed the value |

## Verification
Every operation gets one operand pair that lands inside the range and one that forces a clamp. This separates the clamp paths from the pass-through paths and shows whether the flag tracks them. A single shifted value runs through all four rounding modes, with dropped bits chosen to be exactly half with an even or odd kept LSB and above half. That separates round-up, ties-to-even, truncation and round-to-odd. Some operand pairs differ between unsigned and signed extension or between immediate zero and sign extension. Shift counts above the legal width check that only the low bits of the count are used.

// File: rtl/fx_pkg.sv
package fx_pkg;

    localparam int MAXW = 130;

    typedef enum logic [3:0] {
        OP_SADDU  = 4'd0,
        OP_SADD   = 4'd1,
        OP_SSUBU  = 4'd2,
        OP_SSUB   = 4'd3,
        OP_AADDU  = 4'd4,
        OP_AADD   = 4'd5,
        OP_ASUBU  = 4'd6,
        OP_ASUB   = 4'd7,
        OP_SMUL   = 4'd8,
        OP_SSRL   = 4'd9,
        OP_SSRA   = 4'd10,
        OP_NCLIPU = 4'd11,
        OP_NCLIP  = 4'd12,
        OP_RSV13  = 4'd13,
        OP_RSV14  = 4'd14,
        OP_RSV15  = 4'd15
    } fx_op_e;

    typedef enum logic [1:0] {
        RM_UP   = 2'd0,
        RM_EVEN = 2'd1,
        RM_TRNC = 2'd2,
        RM_ODD  = 2'd3
    } fx_rmode_e;

    typedef enum logic [1:0] {
        BS_VEC  = 2'd0,
        BS_SCL  = 2'd1,
        BS_IMM  = 2'd2,
        BS_VEC2 = 2'd3
    } fx_bsrc_e;

    function automatic logic is_shift_op(input fx_op_e op);
        return (op == OP_SSRL) || (op == OP_SSRA) ||
               (op == OP_NCLIPU) || (op == OP_NCLIP);
    endfunction

    // Increment to add after dropping the low d bits of v.
    function automatic logic rnd_inc(input logic [MAXW-1:0] v,
                                     input int unsigned d,
                                     input fx_rmode_e m);
        logic [MAXW-1:0] lomask;
        logic keep, half, below, sticky;
        lomask = (MAXW'(1) << d) - MAXW'(1);
        keep   = |(v & (MAXW'(1) << d));
        half   = (d != 0) && (|(v & (MAXW'(1) << (d - 1))));
        below  = |(v & (lomask >> 1));
        sticky = |(v & lomask);
        case (m)
            RM_UP:   return half;
            RM_EVEN: return half & (below | keep);
            RM_TRNC: return 1'b0;
            default: return ~keep & sticky;
        endcase
    endfunction

endpackage

// File: rtl/fx_opsel.sv
module fx_opsel
    import fx_pkg::*;
#(
    parameter int SEW = 8
) (
    input  fx_bsrc_e         bsrc,
    input  fx_op_e           op,
    input  logic [SEW-1:0]   vec_b,
    input  logic [SEW-1:0]   scl_b,
    input  logic [4:0]       imm,
    output logic [SEW-1:0]   b_eff
);
    localparam int PAD = SEW - 5;

    logic [SEW-1:0] imm_ext;

    always_comb begin
        if (is_shift_op(op)) imm_ext = {{PAD{1'b0}}, imm};
        else                 imm_ext = {{PAD{imm[4]}}, imm};
    end

    always_comb begin
        case (bsrc)
            BS_SCL:  b_eff = scl_b;
            BS_IMM:  b_eff = imm_ext;
            default: b_eff = vec_b;
        endcase
    end
endmodule

// File: rtl/fx_core.sv
module fx_core
    import fx_pkg::*;
#(
    parameter int SEW = 8
) (
    input  fx_op_e             op,
    input  fx_rmode_e          rm,
    input  logic [2*SEW-1:0]   a_wide,
    input  logic [SEW-1:0]     b,
    output logic [SEW-1:0]     res,
    output logic               sat
);
    localparam int N    = SEW;
    localparam int W2   = 2 * SEW;
    localparam int SHW  = $clog2(SEW);
    localparam int SHW2 = SHW + 1;
    localparam logic [N-1:0] SMAX = {1'b0, {(N-1){1'b1}}};
    localparam logic [N-1:0] SMIN = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0]    a;
    logic [N:0]      sum_u, sum_s, dif_u, dif_s;
    logic [W2-1:0]   prod;
    logic [N:0]      mul_w;
    logic [SHW-1:0]  shn;
    logic [SHW2-1:0] shw;
    logic [N-1:0]    srl_v, sra_v;
    logic [W2-1:0]   nsrl, nsra, nw_u, nw_s;
    logic [N:0]      nhi;
    logic inc_au, inc_as, inc_du, inc_ds, inc_mul, inc_sh, inc_n;

    assign a     = a_wide[N-1:0];
    assign sum_u = {1'b0, a} + {1'b0, b};
    assign sum_s = {a[N-1], a} + {b[N-1], b};
    assign dif_u = {1'b0, a} - {1'b0, b};
    assign dif_s = {a[N-1], a} - {b[N-1], b};
    assign prod  = W2'($signed({{N{a[N-1]}}, a}) * $signed({{N{b[N-1]}}, b}));
    assign shn   = b[SHW-1:0];
    assign shw   = b[SHW2-1:0];
    assign srl_v = a >> shn;
    assign sra_v = $signed(a) >>> shn;
    assign nsrl  = a_wide >> shw;
    assign nsra  = $signed(a_wide) >>> shw;

    assign inc_au  = rnd_inc(MAXW'(sum_u), 32'd1, rm);
    assign inc_as  = rnd_inc(MAXW'(sum_s), 32'd1, rm);
    assign inc_du  = rnd_inc(MAXW'(dif_u), 32'd1, rm);
    assign inc_ds  = rnd_inc(MAXW'(dif_s), 32'd1, rm);
    assign inc_mul = rnd_inc(MAXW'(prod), 32'(N - 1), rm);
    assign inc_sh  = rnd_inc(MAXW'(a), 32'(shn), rm);
    assign inc_n   = rnd_inc(MAXW'(a_wide), 32'(shw), rm);

    assign mul_w = prod[W2-1:N-1] + {{N{1'b0}}, inc_mul};
    assign nw_u  = nsrl + {{(W2-1){1'b0}}, inc_n};
    assign nw_s  = nsra + {{(W2-1){1'b0}}, inc_n};
    assign nhi   = nw_s[W2-1:N-1];

    always_comb begin
        res = '0;
        sat = 1'b0;
        case (op)
            OP_SADDU: begin
                sat = sum_u[N];
                res = sat ? {N{1'b1}} : sum_u[N-1:0];
            end
            OP_SADD: begin
                sat = sum_s[N] ^ sum_s[N-1];
                res = sat ? (sum_s[N] ? SMIN : SMAX) : sum_s[N-1:0];
            end
            OP_SSUBU: begin
                sat = dif_u[N];
                res = sat ? '0 : dif_u[N-1:0];
            end
            OP_SSUB: begin
                sat = dif_s[N] ^ dif_s[N-1];
                res = sat ? (dif_s[N] ? SMIN : SMAX) : dif_s[N-1:0];
            end
            OP_AADDU: res = sum_u[N:1] + {{(N-1){1'b0}}, inc_au};
            OP_AADD:  res = sum_s[N:1] + {{(N-1){1'b0}}, inc_as};
            OP_ASUBU: res = dif_u[N:1] + {{(N-1){1'b0}}, inc_du};
            OP_ASUB:  res = dif_s[N:1] + {{(N-1){1'b0}}, inc_ds};
            OP_SMUL: begin
                sat = mul_w[N] ^ mul_w[N-1];
                res = sat ? (mul_w[N] ? SMIN : SMAX) : mul_w[N-1:0];
            end
            OP_SSRL: res = srl_v + {{(N-1){1'b0}}, inc_sh};
            OP_SSRA: res = sra_v + {{(N-1){1'b0}}, inc_sh};
            OP_NCLIPU: begin
                sat = |nw_u[W2-1:N];
                res = sat ? {N{1'b1}} : nw_u[N-1:0];
            end
            OP_NCLIP: begin
                sat = !((&nhi) || (~|nhi));
                res = sat ? (nw_s[W2-1] ? SMIN : SMAX) : nw_s[N-1:0];
            end
            default: begin
                res = '0;
                sat = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fxalu.sv
module fxalu
    import fx_pkg::*;
#(
    parameter int SEW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [3:0]         op_i,
    input  logic [1:0]         rmode_i,
    input  logic [1:0]         bsrc_i,
    input  logic [2*SEW-1:0]   opa_i,
    input  logic [SEW-1:0]     vec_b_i,
    input  logic [SEW-1:0]     scl_b_i,
    input  logic [4:0]         imm_i,
    output logic               out_valid,
    output logic [SEW-1:0]     result_o,
    output logic               sat_o
);
    localparam logic [SEW-1:0] SMAX = {1'b0, {(SEW-1){1'b1}}};
    localparam logic [SEW-1:0] SMIN = {1'b1, {(SEW-1){1'b0}}};

    fx_op_e         op;
    fx_rmode_e      rm;
    fx_bsrc_e       bsrc;
    logic [SEW-1:0] b_eff;
    logic [SEW-1:0] res_c;
    logic           sat_c;

    assign op   = fx_op_e'(op_i);
    assign rm   = fx_rmode_e'(rmode_i);
    assign bsrc = fx_bsrc_e'(bsrc_i);

    fx_opsel #(.SEW(SEW)) opsel_i (
        .bsrc  (bsrc),
        .op    (op),
        .vec_b (vec_b_i),
        .scl_b (scl_b_i),
        .imm   (imm_i),
        .b_eff (b_eff)
    );

    fx_core #(.SEW(SEW)) core_i (
        .op     (op),
        .rm     (rm),
        .a_wide (opa_i),
        .b      (b_eff),
        .res    (res_c),
        .sat    (sat_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result_o  <= '0;
            sat_o     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            result_o  <= in_valid ? res_c : '0;
            sat_o     <= in_valid & sat_c;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !sat_o && result_o == '0));

    assert_uadd_clamp_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_SADDU) |=> (!sat_o || result_o == {SEW{1'b1}}));

    assert_usub_floor_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_SSUBU && opa_i[SEW-1:0] < b_eff)
        |=> (sat_o && result_o == '0));

    assert_signed_limits_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == OP_SADD || op == OP_SSUB || op == OP_SMUL || op == OP_NCLIP))
        |=> (!sat_o || result_o == SMAX || result_o == SMIN));

    assert_avg_no_sat_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == OP_AADDU || op == OP_AADD || op == OP_ASUBU || op == OP_ASUB))
        |=> !sat_o);

    assert_shift_no_sat_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == OP_SSRL || op == OP_SSRA)) |=> !sat_o);

    assert_uclip_limit_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_NCLIPU) |=> (!sat_o || result_o == {SEW{1'b1}}));
endmodule

// File: tb/fxalu_tb_top.sv
module fxalu_tb_top;
    localparam int SEW = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [3:0]     op_i = '0;
    logic [1:0]     rmode_i = '0;
    logic [1:0]     bsrc_i = '0;
    logic [15:0]    opa_i = '0;
    logic [7:0]     vec_b_i = '0;
    logic [7:0]     scl_b_i = '0;
    logic [4:0]     imm_i = '0;
    logic           out_valid;
    logic [7:0]     result_o;
    logic           sat_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    fxalu #(.SEW(SEW)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_i(op_i),
        .rmode_i(rmode_i), .bsrc_i(bsrc_i), .opa_i(opa_i),
        .vec_b_i(vec_b_i), .scl_b_i(scl_b_i), .imm_i(imm_i),
        .out_valid(out_valid), .result_o(result_o), .sat_o(sat_o)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    task automatic check(input string req, input logic [7:0] exp_r, input logic exp_s,
                         input logic exp_v);
        n_checks++;
        if (result_o !== exp_r || sat_o !== exp_s || out_valid !== exp_v) begin
            n_fail++;
            $display("FAIL %s: result=%h sat=%b valid=%b expected result=%h sat=%b valid=%b",
                     req, result_o, sat_o, out_valid, exp_r, exp_s, exp_v);
        end
    endtask

    // Drive at the falling edge, sample after the next rising edge.
    task automatic apply(input string req, input logic [3:0] op, input logic [1:0] rm,
                         input logic [1:0] bs, input logic [15:0] a, input logic [7:0] vb,
                         input logic [7:0] sb, input logic [4:0] im,
                         input logic [7:0] exp_r, input logic exp_s);
        @(negedge clk);
        in_valid = 1'b1; op_i = op; rmode_i = rm; bsrc_i = bs;
        opa_i = a; vec_b_i = vb; scl_b_i = sb; imm_i = im;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, exp_r, exp_s, 1'b1);
    endtask

    task automatic vv(input string req, input logic [3:0] op, input logic [1:0] rm,
                      input logic [15:0] a, input logic [7:0] b,
                      input logic [7:0] exp_r, input logic exp_s);
        apply(req, op, rm, 2'd0, a, b, 8'h00, 5'd0, exp_r, exp_s);
    endtask

    task automatic t_reset_R1();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset", 8'h00, 1'b0, 1'b0);
        rst = 1'b0;
        vv("R1 issue", 4'd0, 2'd0, 16'h0014, 8'h1E, 8'h32, 1'b0);
        @(negedge clk);
        check("R1 idle", 8'h00, 1'b0, 1'b0);
    endtask

    task automatic t_uadd_R2();
        vv("R2 clamp", 4'd0, 2'd0, 16'h00C8, 8'h64, 8'hFF, 1'b1);
        vv("R2 exact", 4'd0, 2'd0, 16'h0014, 8'h1E, 8'h32, 1'b0);
    endtask

    task automatic t_usub_R3();
        vv("R3 floor", 4'd2, 2'd0, 16'h000A, 8'h14, 8'h00, 1'b1);
        vv("R3 exact", 4'd2, 2'd0, 16'h0032, 8'h14, 8'h1E, 1'b0);
    endtask

    task automatic t_signed_R4();
        vv("R4 add hi", 4'd1, 2'd0, 16'h0064, 8'h64, 8'h7F, 1'b1);
        vv("R4 add lo", 4'd1, 2'd0, 16'h009C, 8'h9C, 8'h80, 1'b1);
        vv("R4 sub lo", 4'd3, 2'd0, 16'h0080, 8'h01, 8'h80, 1'b1);
        vv("R4 sub ok", 4'd3, 2'd0, 16'h0005, 8'h07, 8'hFE, 1'b0);
    endtask

    task automatic t_avg_R5();
        vv("R5 aaddu up",   4'd4, 2'd0, 16'h0005, 8'h06, 8'h06, 1'b0);
        vv("R5 aaddu trnc", 4'd4, 2'd2, 16'h0005, 8'h06, 8'h05, 1'b0);
        vv("R5 aadd neg",   4'd5, 2'd0, 16'h00FD, 8'h00, 8'hFF, 1'b0);
        vv("R5 asubu neg",  4'd6, 2'd0, 16'h0003, 8'h0A, 8'hFD, 1'b0);
        vv("R5 asub wide",  4'd7, 2'd0, 16'h0064, 8'h9C, 8'h64, 1'b0);
    endtask

    task automatic t_mul_R6();
        vv("R6 half sq",  4'd8, 2'd0, 16'h0040, 8'h40, 8'h20, 1'b0);
        vv("R6 neg",      4'd8, 2'd0, 16'h0060, 8'hC0, 8'hD0, 1'b0);
        vv("R6 round",    4'd8, 2'd0, 16'h0003, 8'h40, 8'h02, 1'b0);
        vv("R6 min sq",   4'd8, 2'd0, 16'h0080, 8'h80, 8'h7F, 1'b1);
    endtask

    task automatic t_shift_R7();
        vv("R7 srl mask", 4'd9,  2'd2, 16'h0080, 8'h0B, 8'h10, 1'b0);
        vv("R7 sra",      4'd10, 2'd2, 16'h0080, 8'h03, 8'hF0, 1'b0);
        vv("R7 sra rnd",  4'd10, 2'd0, 16'h00F9, 8'h01, 8'hFD, 1'b0);
    endtask

    task automatic t_round_R8();
        // 0x0A>>2 = 2.5, 0x0E>>2 = 3.5
        vv("R8 up tie",    4'd9, 2'd0, 16'h000A, 8'h02, 8'h03, 1'b0);
        vv("R8 even tie",  4'd9, 2'd1, 16'h000A, 8'h02, 8'h02, 1'b0);
        vv("R8 trnc tie",  4'd9, 2'd2, 16'h000A, 8'h02, 8'h02, 1'b0);
        vv("R8 odd tie",   4'd9, 2'd3, 16'h000A, 8'h02, 8'h03, 1'b0);
        vv("R8 up odd",    4'd9, 2'd0, 16'h000E, 8'h02, 8'h04, 1'b0);
        vv("R8 even odd",  4'd9, 2'd1, 16'h000E, 8'h02, 8'h04, 1'b0);
        vv("R8 trnc odd",  4'd9, 2'd2, 16'h000E, 8'h02, 8'h03, 1'b0);
        vv("R8 odd odd",   4'd9, 2'd3, 16'h000E, 8'h02, 8'h03, 1'b0);
        vv("R8 even abv",  4'd9, 2'd1, 16'h000B, 8'h02, 8'h03, 1'b0);
    endtask

    task automatic t_clip_R9();
        vv("R9 u clamp",  4'd11, 2'd2, 16'h1234, 8'h04, 8'hFF, 1'b1);
        vv("R9 u round",  4'd11, 2'd0, 16'h0AB8, 8'h04, 8'hAC, 1'b0);
        vv("R9 u modulo", 4'd11, 2'd0, 16'h0AB8, 8'h14, 8'hAC, 1'b0);
        vv("R9 s low",    4'd12, 2'd0, 16'hF000, 8'h04, 8'h80, 1'b1);
        vv("R9 s exact",  4'd12, 2'd0, 16'hFF38, 8'h01, 8'h9C, 1'b0);
        vv("R9 s high",   4'd12, 2'd0, 16'h7FFF, 8'h00, 8'h7F, 1'b1);
    endtask

    task automatic t_source_R10();
        apply("R10 scalar",   4'd0, 2'd0, 2'd1, 16'h0001, 8'h64, 8'h02, 5'h00, 8'h03, 1'b0);
        apply("R10 imm sext", 4'd0, 2'd0, 2'd2, 16'h0001, 8'h00, 8'h00, 5'h1F, 8'hFF, 1'b1);
        apply("R10 imm sadd", 4'd1, 2'd0, 2'd2, 16'h000A, 8'h00, 8'h00, 5'h1F, 8'h09, 1'b0);
        apply("R10 imm shft", 4'd9, 2'd2, 2'd2, 16'h0080, 8'h00, 8'h00, 5'h1F, 8'h01, 1'b0);
        apply("R10 sel3 vec", 4'd0, 2'd0, 2'd3, 16'h0001, 8'h04, 8'h50, 5'h07, 8'h05, 1'b0);
    endtask

    initial begin
        #(8 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        t_reset_R1();
        t_uadd_R2();
        t_usub_R3();
        t_signed_R4();
        t_avg_R5();
        t_mul_R6();
        t_shift_R7();
        t_round_R8();
        t_clip_R9();
        t_source_R10();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule